// File: doc/BRIEF.md
# Delayed Coincidence Record Selector

This block applies a look-back coincidence trigger to a single merged stream of timestamped detector records. Each record carries a timestamp, a one-bit source tag and a payload. Records from the early detector group (the target array) are kept in a small time-ordered ring. A record from the late group (the recoil plane) arrives one flight time after the prompt activity that caused it. When it does, the block scans the ring and emits the stored target records whose age, measured back from the recoil timestamp, falls inside a window that starts one flight time earlier. It then emits the recoil record itself.

The flight-time offset `TOF` and the window width `WIN` are parameters in clock ticks. With the defaults, the block looks back at most `TOF + WIN` ticks. A target record is never consumed by a selection, so it can belong to several recoils. Records older than the deepest possible look-back are dropped from the ring. If the ring fills with live records anyway, the oldest one is overwritten and a counter records the loss. While an event is being emitted, the input is stalled through `in_ready`.

Top module: `coinc_selector`

## Requirements
- R1: Source tag encoding is 0 for a target record and 1 for a recoil record. A record is taken on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` is high whenever no event is being emitted, and low from the edge that takes a recoil until that recoil's own word has been output.
- R2: For a recoil with timestamp Tr, a stored target with timestamp Tt is emitted exactly when TOF <= Tr - Tt <= TOF + WIN. Both limits are inclusive.
- R3: An event's emitted target words appear in increasing timestamp order with `out_last` = 0 and `out_nomatch` = 0. They are followed by the recoil word, which carries `out_src` = 1 and `out_last` = 1.
- R4: Emitting a target record does not remove it, so a later recoil whose window also covers it emits it again.
- R5: A recoil whose window holds no stored target is still output as a single word, with `out_last` = 1 and `out_nomatch` = 1.
- R6: Stored targets older than TOF + WIN ticks, measured against the most recently accepted timestamp, are removed and free their slot.
- R7: A target accepted while all DEPTH slots hold live records overwrites the oldest one, and `ovf_count` increments by one. Otherwise `ovf_count` never changes.
- R8: A synchronous active-high reset empties the ring, clears `ovf_count`, deasserts `out_valid` and leaves `in_ready` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input record present |
| in_ready | output | 1 | Block can take a record this cycle |
| in_ts | input | 32 | Input timestamp in ticks |
| in_src | input | 1 | Input source tag: 0 target, 1 recoil |
| in_data | input | 16 | Input payload |
| out_valid | output | 1 | Output word present (one cycle per word) |
| out_ts | output | 32 | Output timestamp |
| out_src | output | 1 | Output source tag |
| out_data | output | 16 | Output payload |
| out_last | output | 1 | Last word of an event (the recoil) |
| out_nomatch | output | 1 | Recoil emitted with no target in its window |
| ovf_count | output | OVF_W | Count of live records lost to a full ring |

## Verification
On every cycle, the checker confirms four things. Each emitted target lies inside the window of the recoil most recently taken. Targets within one event come out in non-decreasing time order and never carry the last or no-match flags. Every last word is that same recoil, and its no-match flag agrees with whether any target preceded it. The overflow counter only holds or steps by one. Other behaviours only show up through the bench's scenarios: which targets are selected at the inclusive window edges, reuse of a target by two recoils, eviction freeing room so that no overflow occurs, and which record is lost when the ring overflows.

// File: rtl/coinc_pkg.sv
package coinc_pkg;

    localparam int unsigned TS_W   = 32;
    localparam int unsigned DATA_W = 16;

    typedef enum logic {
        SRC_TGT = 1'b0,
        SRC_RCL = 1'b1
    } src_e;

    typedef struct packed {
        logic [TS_W-1:0]   ts;
        src_e              src;
        logic [DATA_W-1:0] data;
    } rec_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_CLOSE = 2'd2
    } scan_st_e;

    // Ticks elapsed from an older stamp to a newer one.
    function automatic logic [TS_W-1:0] age_of(input logic [TS_W-1:0] newer,
                                               input logic [TS_W-1:0] older);
        return newer - older;
    endfunction

    // Inclusive window test on an age value.
    function automatic logic age_in_window(input logic [TS_W-1:0] age,
                                           input logic [TS_W-1:0] lo,
                                           input logic [TS_W-1:0] hi);
        return (age >= lo) && (age <= hi);
    endfunction

endpackage

// File: rtl/coinc_ring.sv
module coinc_ring
    import coinc_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  rec_t             wr_rec,
    input  logic [PTR_W-1:0] rd_idx,
    output rec_t             rd_rec,
    output rec_t             head_rec,
    output logic [PTR_W-1:0] head_idx,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

    rec_t             mem [DEPTH];
    logic [PTR_W-1:0] head_q;
    logic [PTR_W-1:0] tail_q;
    logic [CNT_W-1:0] cnt_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_SLOT) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            mem[tail_q] <= wr_rec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) begin
                tail_q <= bump(tail_q);
            end
            if (pop) begin
                head_q <= bump(head_q);
            end
            unique case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign rd_rec   = mem[rd_idx];
    assign head_rec = mem[head_q];
    assign head_idx = head_q;
    assign count    = cnt_q;
    assign full     = (cnt_q == FULL_CNT);
    assign empty    = (cnt_q == '0);

endmodule

// File: rtl/coinc_evict.sv
module coinc_evict
    import coinc_pkg::*;
#(
    parameter int unsigned TOF   = 1250,
    parameter int unsigned WIN   = 250,
    parameter int unsigned OVF_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             idle,
    input  logic             accept,
    input  logic [TS_W-1:0]  accept_ts,
    input  logic             push,
    input  logic             full,
    input  logic             empty,
    input  logic [TS_W-1:0]  head_ts,
    output logic             pop,
    output logic [OVF_W-1:0] ovf_count
);

    localparam logic [TS_W-1:0] SPAN = TS_W'(TOF + WIN);

    logic [TS_W-1:0]  now_ts;
    logic [OVF_W-1:0] ovf_q;
    logic             stale;
    logic             evict;
    logic             overrun;

    // Timestamp of the newest record taken, any source.
    always_ff @(posedge clk) begin
        if (rst) begin
            now_ts <= '0;
        end else if (accept) begin
            now_ts <= accept_ts;
        end
    end

    // Only idle cycles retire old entries, so a scan sees a frozen ring.
    assign stale   = !empty && (age_of(now_ts, head_ts) > SPAN);
    assign evict   = idle && stale;
    assign overrun = push && full && !evict;
    assign pop     = evict || (push && full);

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= '0;
        end else if (overrun) begin
            ovf_q <= ovf_q + 1'b1;
        end
    end

    assign ovf_count = ovf_q;

endmodule

// File: rtl/coinc_scan.sv
module coinc_scan
    import coinc_pkg::*;
#(
    parameter int unsigned TOF   = 1250,
    parameter int unsigned WIN   = 250,
    parameter int unsigned DEPTH = 64,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_fire,
    input  rec_t             in_rec,
    input  logic [PTR_W-1:0] head_idx,
    input  logic [CNT_W-1:0] count,
    input  rec_t             rd_rec,
    output logic [PTR_W-1:0] rd_idx,
    output logic             idle,
    output logic             out_valid,
    output rec_t             out_rec,
    output logic             out_last,
    output logic             out_nomatch
);

    localparam logic [TS_W-1:0]  AGE_LO    = TS_W'(TOF);
    localparam logic [TS_W-1:0]  AGE_HI    = TS_W'(TOF + WIN);
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

    scan_st_e         st_q;
    rec_t             rcl_q;
    logic [PTR_W-1:0] idx_q;
    logic [CNT_W-1:0] left_q;
    logic             hit_q;
    logic [TS_W-1:0]  cand_age;
    logic             too_young;
    logic             done;

    assign cand_age  = age_of(rcl_q.ts, rd_rec.ts);
    assign too_young = cand_age < AGE_LO;
    // Ring is time-ordered: the first entry younger than TOF ends the scan.
    assign done      = (left_q == '0) || too_young;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            rcl_q       <= '0;
            idx_q       <= '0;
            left_q      <= '0;
            hit_q       <= 1'b0;
            out_valid   <= 1'b0;
            out_rec     <= '0;
            out_last    <= 1'b0;
            out_nomatch <= 1'b0;
        end else begin
            out_valid   <= 1'b0;
            out_last    <= 1'b0;
            out_nomatch <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (in_fire && in_rec.src == SRC_RCL) begin
                        rcl_q  <= in_rec;
                        idx_q  <= head_idx;
                        left_q <= count;
                        hit_q  <= 1'b0;
                        st_q   <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (done) begin
                        st_q <= ST_CLOSE;
                    end else begin
                        if (age_in_window(cand_age, AGE_LO, AGE_HI)) begin
                            out_valid <= 1'b1;
                            out_rec   <= rd_rec;
                            hit_q     <= 1'b1;
                        end
                        idx_q  <= (idx_q == LAST_SLOT) ? '0 : idx_q + 1'b1;
                        left_q <= left_q - 1'b1;
                    end
                end
                ST_CLOSE: begin
                    out_valid   <= 1'b1;
                    out_rec     <= rcl_q;
                    out_last    <= 1'b1;
                    out_nomatch <= !hit_q;
                    st_q        <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign rd_idx = idx_q;
    assign idle   = (st_q == ST_IDLE);

endmodule

// File: rtl/coinc_selector.sv
module coinc_selector
    import coinc_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned TOF   = 1250,
    parameter int unsigned WIN   = 250,
    parameter int unsigned OVF_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [TS_W-1:0]   in_ts,
    input  logic              in_src,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [TS_W-1:0]   out_ts,
    output logic              out_src,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic              out_nomatch,
    output logic [OVF_W-1:0]  ovf_count
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    rec_t             in_rec;
    rec_t             rd_rec;
    rec_t             head_rec;
    rec_t             out_rec;
    logic [PTR_W-1:0] rd_idx;
    logic [PTR_W-1:0] head_idx;
    logic [CNT_W-1:0] count;
    logic             full;
    logic             empty;
    logic             idle;
    logic             in_fire;
    logic             push;
    logic             pop;

    assign in_rec.ts   = in_ts;
    assign in_rec.src  = src_e'(in_src);
    assign in_rec.data = in_data;

    assign in_ready = idle;
    assign in_fire  = in_valid && idle;
    assign push     = in_fire && (in_rec.src == SRC_TGT);

    coinc_ring #(
        .DEPTH (DEPTH)
    ) u_ring (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .pop      (pop),
        .wr_rec   (in_rec),
        .rd_idx   (rd_idx),
        .rd_rec   (rd_rec),
        .head_rec (head_rec),
        .head_idx (head_idx),
        .count    (count),
        .full     (full),
        .empty    (empty)
    );

    coinc_evict #(
        .TOF   (TOF),
        .WIN   (WIN),
        .OVF_W (OVF_W)
    ) u_evict (
        .clk       (clk),
        .rst       (rst),
        .idle      (idle),
        .accept    (in_fire),
        .accept_ts (in_ts),
        .push      (push),
        .full      (full),
        .empty     (empty),
        .head_ts   (head_rec.ts),
        .pop       (pop),
        .ovf_count (ovf_count)
    );

    coinc_scan #(
        .TOF   (TOF),
        .WIN   (WIN),
        .DEPTH (DEPTH)
    ) u_scan (
        .clk         (clk),
        .rst         (rst),
        .in_fire     (in_fire),
        .in_rec      (in_rec),
        .head_idx    (head_idx),
        .count       (count),
        .rd_rec      (rd_rec),
        .rd_idx      (rd_idx),
        .idle        (idle),
        .out_valid   (out_valid),
        .out_rec     (out_rec),
        .out_last    (out_last),
        .out_nomatch (out_nomatch)
    );

    assign out_ts   = out_rec.ts;
    assign out_src  = logic'(out_rec.src);
    assign out_data = out_rec.data;

endmodule

// File: rtl/coinc_chk.sv
module coinc_chk
    import coinc_pkg::*;
#(
    parameter int unsigned TOF   = 1250,
    parameter int unsigned WIN   = 250,
    parameter int unsigned OVF_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic [TS_W-1:0]  in_ts,
    input logic             in_src,
    input logic             out_valid,
    input logic [TS_W-1:0]  out_ts,
    input logic             out_src,
    input logic             out_last,
    input logic             out_nomatch,
    input logic [OVF_W-1:0] ovf_count
);

    localparam logic [TS_W-1:0] LO = TS_W'(TOF);
    localparam logic [TS_W-1:0] HI = TS_W'(TOF + WIN);

    logic [TS_W-1:0] rcl_ts;
    logic [TS_W-1:0] prev_tgt_ts;
    logic            tgt_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            rcl_ts      <= '0;
            prev_tgt_ts <= '0;
            tgt_seen    <= 1'b0;
        end else begin
            if (in_valid && in_ready && in_src) begin
                rcl_ts <= in_ts;
            end
            if (out_valid && out_last) begin
                prev_tgt_ts <= '0;
                tgt_seen    <= 1'b0;
            end else if (out_valid && !out_src) begin
                prev_tgt_ts <= out_ts;
                tgt_seen    <= 1'b1;
            end
        end
    end

    AST_BUSY_STALL: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_last |-> !in_ready); // R1

    AST_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_src |-> ((rcl_ts - out_ts) >= LO) && ((rcl_ts - out_ts) <= HI)); // R2

    AST_TGT_ORDER: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_src |-> out_ts >= prev_tgt_ts); // R3

    AST_TGT_FLAGS: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_src |-> !out_last && !out_nomatch); // R3

    AST_LAST_IS_RECOIL: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_last |-> out_src && (out_ts == rcl_ts)); // R3

    AST_NOMATCH_FLAG: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_last |-> (out_nomatch == !tgt_seen)); // R5

    AST_OVF_STEP: assert property (@(posedge clk) disable iff (rst)
        (ovf_count == $past(ovf_count)) || (ovf_count == OVF_W'($past(ovf_count) + 1'b1))); // R7

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid && in_ready && (ovf_count == '0)); // R8

endmodule

bind coinc_selector coinc_chk #(
    .TOF   (TOF),
    .WIN   (WIN),
    .OVF_W (OVF_W)
) u_chk (.*);

// File: tb/test_coinc_selector.sv
module test_coinc_selector;
    import coinc_pkg::*;

    localparam int unsigned DEPTH = 8;
    localparam int unsigned TOF   = 50;
    localparam int unsigned WIN   = 10;
    localparam int unsigned OVF_W = 16;
    localparam int          NVEC  = 15;
    localparam int          MAXW  = 64;

    // {src, ts, data}
    localparam logic [48:0] VEC [NVEC] = '{
        {1'b0, 32'd100, 16'd1100},
        {1'b0, 32'd110, 16'd1110},
        {1'b0, 32'd115, 16'd1115},
        {1'b0, 32'd120, 16'd1120},
        {1'b1, 32'd170, 16'd2170},
        {1'b1, 32'd171, 16'd2171},
        {1'b0, 32'd200, 16'd1200},
        {1'b1, 32'd230, 16'd2230},
        {1'b0, 32'd300, 16'd1300},
        {1'b1, 32'd350, 16'd2350},
        {1'b1, 32'd360, 16'd2360},
        {1'b1, 32'd361, 16'd2361},
        {1'b0, 32'd400, 16'd1400},
        {1'b0, 32'd405, 16'd1405},
        {1'b1, 32'd455, 16'd2455}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [TS_W-1:0]   in_ts = '0;
    logic              in_src = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              out_valid;
    logic [TS_W-1:0]   out_ts;
    logic              out_src;
    logic [DATA_W-1:0] out_data;
    logic              out_last;
    logic              out_nomatch;
    logic [OVF_W-1:0]  ovf_count;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // word = {ts, src, data, last, nomatch}
    logic [50:0] got [MAXW];
    logic [50:0] exp_w [MAXW];
    int          n_got = 0;
    int          n_exp = 0;
    logic [31:0] mdl_ts [MAXW];
    logic [15:0] mdl_data [MAXW];
    int          n_mdl = 0;

    always #2 clk = ~clk;

    coinc_selector #(
        .DEPTH (DEPTH),
        .TOF   (TOF),
        .WIN   (WIN),
        .OVF_W (OVF_W)
    ) i_coinc_selector (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_ts       (in_ts),
        .in_src      (in_src),
        .in_data     (in_data),
        .out_valid   (out_valid),
        .out_ts      (out_ts),
        .out_src     (out_src),
        .out_data    (out_data),
        .out_last    (out_last),
        .out_nomatch (out_nomatch),
        .ovf_count   (ovf_count)
    );

    always @(negedge clk) begin
        if (!rst && out_valid && n_got < MAXW) begin
            got[n_got] = {out_ts, out_src, out_data, out_last, out_nomatch};
            n_got = n_got + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic send(input logic src, input logic [31:0] ts, input logic [15:0] data);
        @(negedge clk);
        in_valid = 1'b1;
        in_src   = src;
        in_ts    = ts;
        in_data  = data;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (30) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        n_got = 0;
        n_exp = 0;
        n_mdl = 0;
    endtask

    task automatic expect_word(input logic [31:0] ts, input logic src, input logic [15:0] data,
                               input logic last, input logic nm);
        exp_w[n_exp] = {ts, src, data, last, nm};
        n_exp++;
    endtask

    // Reference selection straight from the window rule.
    task automatic model(input logic src, input logic [31:0] ts, input logic [15:0] data);
        bit any;
        if (!src) begin
            mdl_ts[n_mdl]   = ts;
            mdl_data[n_mdl] = data;
            n_mdl++;
        end else begin
            any = 1'b0;
            for (int k = 0; k < n_mdl; k++) begin
                if ((ts - mdl_ts[k]) >= TOF && (ts - mdl_ts[k]) <= TOF + WIN) begin
                    expect_word(mdl_ts[k], 1'b0, mdl_data[k], 1'b0, 1'b0);
                    any = 1'b1;
                end
            end
            expect_word(ts, 1'b1, data, 1'b1, !any);
        end
    endtask

    task automatic cmp_stream(input string req);
        chk(n_got == n_exp, req, "word count", 64'(n_got), 64'(n_exp));
        for (int k = 0; k < n_exp; k++) begin
            chk(k < n_got && got[k] === exp_w[k], req, $sformatf("word %0d", k),
                64'(got[k]), 64'(exp_w[k]));
        end
        n_got = 0;
        n_exp = 0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R8: reset state
        do_reset();
        chk(in_ready == 1'b1, "R8", "in_ready", 64'(in_ready), 64'd1);
        chk(out_valid == 1'b0, "R8", "out_valid", 64'(out_valid), 64'd0);
        chk(ovf_count == '0, "R8", "ovf_count", 64'(ovf_count), 64'd0);

        // R2 R3 R4 R5: vector table walked against the window model
        for (int v = 0; v < NVEC; v++) begin
            model(VEC[v][48], VEC[v][47:16], VEC[v][15:0]);
            send(VEC[v][48], VEC[v][47:16], VEC[v][15:0]);
        end
        drain();
        cmp_stream("R2_R3_R4_R5");

        // R5: recoil into an empty ring
        do_reset();
        send(1'b1, 32'd5, 16'd7);
        drain();
        expect_word(32'd5, 1'b1, 16'd7, 1'b1, 1'b1);
        cmp_stream("R5");

        // R6: stale entry retired, so nine pushes fit in eight slots
        do_reset();
        send(1'b0, 32'd10, 16'd10);
        for (int k = 0; k < 8; k++) send(1'b0, 32'(100 + k), 16'(100 + k));
        chk(ovf_count == '0, "R6", "ovf after eviction", 64'(ovf_count), 64'd0);
        send(1'b1, 32'd160, 16'd160);
        drain();
        for (int k = 0; k < 8; k++) expect_word(32'(100 + k), 1'b0, 16'(100 + k), 1'b0, 1'b0);
        expect_word(32'd160, 1'b1, 16'd160, 1'b1, 1'b0);
        cmp_stream("R6");

        // R7 and R1: overflow drops the oldest; input stalls during an event
        do_reset();
        for (int k = 0; k < 9; k++) send(1'b0, 32'(1000 + k), 16'(k));
        chk(ovf_count == 16'd1, "R7", "ovf_count", 64'(ovf_count), 64'd1);
        send(1'b1, 32'd1055, 16'hBEEF);
        chk(in_ready == 1'b0, "R1", "in_ready during event", 64'(in_ready), 64'd0);
        drain();
        chk(in_ready == 1'b1, "R1", "in_ready after event", 64'(in_ready), 64'd1);
        for (int k = 1; k <= 5; k++) expect_word(32'(1000 + k), 1'b0, 16'(k), 1'b0, 1'b0);
        expect_word(32'd1055, 1'b1, 16'hBEEF, 1'b1, 1'b0);
        cmp_stream("R7");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule